// File: doc/BRIEF.md
# Serially Configured Logic Cell

A single programmable logic cell whose behaviour is set by a string of configuration bits. The bits are shifted in one at a time on their own clock. A 4-input lookup table is built as a 16:1 selector over sixteen of these bits. Two more bits choose what the main output shows and whether the cell runs as one stage of a ripple adder.

A data flip-flop runs on its own system clock. Its input is either the cell's combinational result or the raw `in_a` signal, and a run-time select input makes that choice. This lets the cell hold `in_a` in its register while the table computes an unrelated function. The combinational result and the registered value are both available as outputs at all times.

In adder mode the table output is used as the propagate term. The cell then produces a sum bit and a carry toward its neighbour. The configuration is meant to be loaded before operation and left alone while the cell runs. A serial output lets several cells share one configuration stream.

Top module: `cfg_logic_cell`

## Requirements
- R1: With adder mode off, `comb_out` equals table bit number {in_d,in_c,in_b,in_a}, where in_a is the least significant bit of the index.
- R2: On each rising `cfg_clk` with `cfg_en` high, `cfg_din` enters the first stage of an 18-stage chain. After 18 such edges, the first bit loaded is table bit 15, the next ones are bits 14 down to 0, then the output-select bit, then the adder-enable bit. `cfg_dout` shows the last stage, which holds table bit 15 once loading is complete.
- R3: Rising `cfg_clk` edges with `cfg_en` low leave every configuration bit unchanged, whatever `cfg_din` is.
- R4: With `reg_sel` = 1, a rising `clk` loads `comb_out` into the register that drives `reg_out`.
- R5: With `reg_sel` = 0, a rising `clk` loads `in_a` into that register, while `comb_out` keeps following the table.
- R6: `rst` high at a rising `clk` clears `reg_out` to 0 on that edge, and this overrides R4 and R5.
- R7: `main_out` equals `reg_out` when the output-select bit is 1, and equals `comb_out` when it is 0.
- R8: With the adder-enable bit at 1 and table output p, `comb_out` = p XOR `carry_in`. `carry_out` equals `carry_in` when p = 1 and equals `in_a` when p = 0.
- R9: With the adder-enable bit at 0, `carry_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Last chain stage, used for daisy-chaining |
| clk | input | 1 | System clock for the data register |
| rst | input | 1 | Synchronous active-high register clear |
| in_a | input | 1 | Table input, index bit 0; also the bypass data and the adder generate operand |
| in_b | input | 1 | Table input, index bit 1 |
| in_c | input | 1 | Table input, index bit 2 |
| in_d | input | 1 | Table input, index bit 3 |
| reg_sel | input | 1 | Register source: 1 = cell result, 0 = in_a |
| carry_in | input | 1 | Carry from the neighbouring cell |
| carry_out | output | 1 | Carry toward the neighbouring cell |
| comb_out | output | 1 | Combinational result (table value or sum) |
| reg_out | output | 1 | Registered value |
| main_out | output | 1 | Output chosen by the output-select bit |

## Verification
Two things can happen on the same clock edge: the register captures a value, and the combinational path produces a different function. In bypass mode the register takes `in_a` while `comb_out` evaluates the table, and in adder mode a sum and a carry are formed together. The bench drives random table contents and random inputs in both register modes. Before each edge it checks `comb_out` and `carry_out` against a reference function, and after the edge it checks `reg_out` and `main_out`, so a mix-up between the two paths shows up as a mismatch on one of the two outputs.

// File: rtl/cfglc_pkg.sv
package cfglc_pkg;
    localparam int LUT_K     = 4;
    localparam int LUT_BITS  = 1 << LUT_K;
    localparam int CTRL_BITS = 2;
    localparam int CHAIN_LEN = LUT_BITS + CTRL_BITS;

    // Field order matches chain position: table in the far stages,
    // adder enable in stage 0 (the last bit shifted in).
    typedef struct packed {
        logic [LUT_BITS-1:0] table_bits;
        logic                out_sel;
        logic                carry_en;
    } cell_cfg_t;

    typedef struct packed {
        logic q;
    } data_reg_t;
endpackage

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
    parameter int LEN = 18
) (
    input  logic           cfg_clk,
    input  logic           cfg_en,
    input  logic           cfg_din,
    output logic [LEN-1:0] chain_q,
    output logic           cfg_dout
);
    logic [LEN-1:0] chain_d;

    always_comb begin
        chain_d = chain_q;
        if (cfg_en) begin
            chain_d = {chain_q[LEN-2:0], cfg_din};
        end
    end

    always_ff @(posedge cfg_clk) begin
        chain_q <= chain_d;
    end

    assign cfg_dout = chain_q[LEN-1];
endmodule

// File: rtl/lut_select.sv
module lut_select #(
    parameter int K = 4,
    localparam int N = 1 << K
) (
    input  logic [N-1:0] table_bits,
    input  logic [K-1:0] idx,
    output logic         y
);
    // Heap-ordered selector tree: node n has children 2n+1 and 2n+2,
    // the root decides on the most significant index bit.
    logic [2*N-2:0] node;

    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign node[N-1+i] = table_bits[i];
    end

    for (genvar dp = 0; dp < K; dp++) begin : g_level
        for (genvar j = 0; j < (1 << dp); j++) begin : g_node
            localparam int NI = (1 << dp) - 1 + j;
            assign node[NI] = idx[K-1-dp] ? node[2*NI+2] : node[2*NI+1];
        end
    end

    assign y = node[0];
endmodule

// File: rtl/carry_unit.sv
module carry_unit (
    input  logic prop,
    input  logic gen_in,
    input  logic cin,
    input  logic carry_en,
    output logic fn_out,
    output logic cout
);
    always_comb begin
        fn_out = prop;
        cout   = 1'b0;
        if (carry_en) begin
            fn_out = prop ^ cin;
            cout   = prop ? cin : gen_in;
        end
    end
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import cfglc_pkg::*;
(
    input  logic cfg_clk,
    input  logic cfg_en,
    input  logic cfg_din,
    output logic cfg_dout,
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    input  logic in_d,
    input  logic reg_sel,
    input  logic carry_in,
    output logic carry_out,
    output logic comb_out,
    output logic reg_out,
    output logic main_out
);
    logic [CHAIN_LEN-1:0] cfg_q;
    cell_cfg_t            cfg;
    logic                 prop;
    logic                 fn_val;
    data_reg_t            dreg_d, dreg_q;

    cfg_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
        .cfg_clk (cfg_clk),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .chain_q (cfg_q),
        .cfg_dout(cfg_dout)
    );

    assign cfg = cell_cfg_t'(cfg_q);

    lut_select #(.K(LUT_K)) u_lut (
        .table_bits(cfg.table_bits),
        .idx       ({in_d, in_c, in_b, in_a}),
        .y         (prop)
    );

    carry_unit u_carry (
        .prop    (prop),
        .gen_in  (in_a),
        .cin     (carry_in),
        .carry_en(cfg.carry_en),
        .fn_out  (fn_val),
        .cout    (carry_out)
    );

    always_comb begin
        dreg_d   = dreg_q;
        dreg_d.q = reg_sel ? fn_val : in_a;
        if (rst) begin
            dreg_d.q = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        dreg_q <= dreg_d;
    end

    assign comb_out = fn_val;
    assign reg_out  = dreg_q.q;
    assign main_out = cfg.out_sel ? dreg_q.q : fn_val;
endmodule

// File: rtl/cfg_logic_cell_chk.sv
module cfg_logic_cell_chk #(
    parameter int LEN = 18
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_clk,
    input logic           cfg_en,
    input logic           cfg_din,
    input logic [LEN-1:0] cfg_q,
    input logic           in_a,
    input logic           reg_sel,
    input logic           comb_out,
    input logic           reg_out,
    input logic           main_out,
    input logic           carry_out
);
    p_sync_clear_r6: assert property (@(posedge clk)
        rst |=> (reg_out == 1'b0));

    p_result_capture_r4: assert property (@(posedge clk) disable iff (rst)
        reg_sel |=> (reg_out == $past(comb_out)));

    p_bypass_capture_r5: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |=> (reg_out == $past(in_a)));

    p_main_registered_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_q[1] |-> (main_out == reg_out));

    p_carry_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_q[0] |-> !carry_out);

    p_shift_entry_r2: assert property (@(posedge cfg_clk) disable iff (rst)
        cfg_en |=> (cfg_q[0] == $past(cfg_din)));

    p_cfg_hold_r3: assert property (@(posedge cfg_clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_q));
endmodule

bind cfg_logic_cell cfg_logic_cell_chk #(.LEN(cfglc_pkg::CHAIN_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_clk  (cfg_clk),
    .cfg_en   (cfg_en),
    .cfg_din  (cfg_din),
    .cfg_q    (cfg_q),
    .in_a     (in_a),
    .reg_sel  (reg_sel),
    .comb_out (comb_out),
    .reg_out  (reg_out),
    .main_out (main_out),
    .carry_out(carry_out)
);

// File: tb/cfg_logic_cell_test.sv
module cfg_logic_cell_test;
    logic cfg_clk = 0, cfg_en = 0, cfg_din = 0, cfg_dout;
    logic clk = 0, rst = 1;
    logic in_a = 0, in_b = 0, in_c = 0, in_d = 0, reg_sel = 0, carry_in = 0;
    logic carry_out, comb_out, reg_out, main_out;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] cur_tab;
    logic cur_osel, cur_cen;

    cfg_logic_cell uut (
        .cfg_clk(cfg_clk), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
        .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
        .reg_sel(reg_sel), .carry_in(carry_in), .carry_out(carry_out),
        .comb_out(comb_out), .reg_out(reg_out), .main_out(main_out)
    );

    always #10 clk = ~clk;

    function automatic logic ref_fn(logic [15:0] t, logic cen, logic [3:0] ix, logic ci);
        logic p;
        p = t[ix];
        return cen ? (p ^ ci) : p;
    endfunction

    function automatic logic ref_cout(logic [15:0] t, logic cen, logic [3:0] ix, logic ci);
        logic p;
        p = t[ix];
        if (!cen) return 1'b0;
        return p ? ci : ix[0];
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cfg_pulse(logic en, logic din);
        @(negedge clk);
        cfg_en = en; cfg_din = din;
        #2 cfg_clk = 1;
        #2 cfg_clk = 0;
        cfg_en = 0;
    endtask

    task automatic load_cfg(logic [15:0] t, logic osel, logic cen);
        for (int i = 15; i >= 0; i--) cfg_pulse(1'b1, t[i]);
        cfg_pulse(1'b1, osel);
        cfg_pulse(1'b1, cen);
        cur_tab = t; cur_osel = osel; cur_cen = cen;
        #1 check("R2", cfg_dout, t[15]);
    endtask

    task automatic set_in(logic [3:0] ix, logic ci, logic rs);
        {in_d, in_c, in_b, in_a} = ix;
        carry_in = ci; reg_sel = rs;
    endtask

    // Table sweep: every index checked combinationally.
    task automatic sweep(string req);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            set_in(4'(i), 1'b0, 1'b1);
            #2 check(req, comb_out, ref_fn(cur_tab, cur_cen, 4'(i), 1'b0));
        end
    endtask

    // One clocked step with full prediction of both paths.
    task automatic step(logic [3:0] ix, logic ci, logic rs, logic r);
        logic ef, ec, eq;
        @(negedge clk);
        set_in(ix, ci, rs); rst = r;
        ef = ref_fn(cur_tab, cur_cen, ix, ci);
        ec = ref_cout(cur_tab, cur_cen, ix, ci);
        eq = r ? 1'b0 : (rs ? ef : ix[0]);
        #2;
        check(cur_cen ? "R8" : "R1", comb_out, ef);
        check(cur_cen ? "R8" : "R9", carry_out, ec);
        @(posedge clk); #1;
        check(r ? "R6" : (rs ? "R4" : "R5"), reg_out, eq);
        check("R7", main_out, cur_osel ? eq : ef);
        rst = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed_c311));
        repeat (3) @(posedge clk);
        #1 check("R6", reg_out, 1'b0);
        @(negedge clk) rst = 0;

        // Directed: one-hot tables pin the chain order.
        load_cfg(16'h8000, 1'b0, 1'b0); sweep("R1");
        load_cfg(16'h0001, 1'b1, 1'b0); sweep("R1");
        load_cfg(16'h6996, 1'b0, 1'b0); sweep("R1");

        // R3: shifting disabled must not disturb the config.
        load_cfg(16'hA5C3, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) cfg_pulse(1'b0, k[0]);
        #1 check("R3", cfg_dout, 1'b1);
        sweep("R3");
        step(4'h0, 1'b0, 1'b1, 1'b0);
        step(4'h3, 1'b0, 1'b1, 1'b0);

        // Adder mode: table = a XOR b as propagate, exhaustive with carry.
        load_cfg(16'h6666, 1'b0, 1'b1);
        for (int v = 0; v < 32; v++) step(4'(v), v[4], v[2], 1'b0);
        // Reset overrides both capture sources.
        step(4'hF, 1'b1, 1'b1, 1'b1);
        step(4'h1, 1'b0, 1'b0, 1'b1);

        // Bypass while table computes an unrelated function.
        load_cfg(16'h00FF, 1'b1, 1'b0);
        for (int v = 0; v < 16; v++) step(4'(v), 1'b0, 1'b0, 1'b0);

        // Random configurations and stimulus.
        for (int c = 0; c < 30; c++) begin
            load_cfg(16'($urandom), 1'($urandom), 1'($urandom));
            for (int s = 0; s < 24; s++)
                step(4'($urandom), 1'($urandom), 1'($urandom), ($urandom % 16) == 0);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule